// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only slave on a two-wire serial bus (I2C style). It holds a small bank of 8-bit control registers. Each bit enables one clock output or one test-mode function: 1 enables it and 0 disables it. A fast system clock oversamples the bus lines. The block finds START and STOP conditions, checks the first byte against a fixed write address and acknowledges a match. It then requires two filler bytes, a command byte and a count byte. Their contents do not matter, but both must arrive and are acknowledged.

Every byte after the two filler bytes overwrites the next register, beginning at register 0. To change a later register, the master resends all the earlier ones. No register pointer and no read path exist. An active-low power-down input takes the block off the bus. While it is low, the register contents stay as they are.

The top module drives no pin directly. It produces an open-drain enable, `sda_oe`, and the pad logic pulls SDA low while that enable is high.

Top module: `cfg_i2c_wo_slave`

## Requirements
- R1: After reset every register bit reads 1, so every clock is enabled, and `sda_oe` is 0 (SDA released).
- R2: A transfer begins with START (SDA falls while SCL is high). A STOP (SDA rises while SCL is high) ends it. The next transfer again begins with the address byte.
- R3: Bytes are received MSB first. An address byte equal to 0xD2 (7-bit address 0x69, R/W bit 0) is acknowledged by holding SDA low through the ninth SCL pulse.
- R4: Any other address byte, including the read form 0xD3, is not acknowledged. The block then ignores all bytes until the next START.
- R5: The two bytes after an acknowledged address are acknowledged, and their values have no effect on any register.
- R6: Later bytes load register 0, 1, 2, … in that order. Register k appears on `ctrl_o[8k+7:8k]`.
- R7: Data bytes that arrive after the last register has been written are acknowledged and discarded.
- R8: A repeated START inside a transfer restarts at the address byte, and the next data byte goes to register 0 again.
- R9: While `pwr_dn_n` is 0 the block acknowledges nothing and keeps every register unchanged. Once `pwr_dn_n` returns to 1, the next START begins a normal transfer.
- R10: `sda_oe` rises and falls only while SCL is low.
- R11: A register changes only when a data byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down; while it is 0 the bus is ignored |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| ctrl_o | output | 8*NUM_REGS | Control register contents; register k is in bits 8k+7:8k |

## Verification
The checker watches every cycle for three things. `sda_oe` may change only while SCL is low. Register contents may change only after an acknowledge has been driven. During power-down the block must neither acknowledge nor change a register. The bench scenarios are the only way to show the protocol decisions. These are which addresses are acknowledged, that the command and count byte values are ignored, that data fills the registers in order, that extra bytes are discarded, and that a repeated START or a STOP returns the register index to 0. A scoreboard compares each acknowledge bit observed on the wire with the value predicted from the byte sequence.

// File: rtl/i2cwo_pkg.sv
package i2cwo_pkg;

    // Where the receiver is within one byte frame
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_WAITFALL,
        PH_ACK
    } phase_e;

    // Role of the byte being received
    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_CNT,
        BY_DATA
    } byte_e;

    function automatic byte_e next_kind(input byte_e k);
        case (k)
            BY_ADDR: next_kind = BY_CMD;
            BY_CMD:  next_kind = BY_CNT;
            default: next_kind = BY_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2cwo_sync.sv
module i2cwo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  scl_s;

    assign scl_s = st_q.scl_pipe[STAGES-1];
    assign sda_s = st_q.sda_pipe[STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.scl_pipe = {st_q.scl_pipe[STAGES-2:0], scl_i};
        st_d.sda_pipe = {st_q.sda_pipe[STAGES-2:0], sda_i};
        st_d.scl_prev = scl_s;
        st_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_rise  = scl_s & ~st_q.scl_prev;
    assign scl_fall  = ~scl_s & st_q.scl_prev;
    assign start_det = scl_s & st_q.scl_prev & st_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & st_q.scl_prev & ~st_q.sda_prev & sda_s;

endmodule

// File: rtl/i2cwo_engine.sv
module i2cwo_engine
    import i2cwo_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 4,
    localparam int        IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);

    localparam logic [7:0]       MATCH_BYTE = {DEV_ADDR, 1'b0};
    localparam logic [IDX_W-1:0] IDX_LIMIT  = IDX_W'(NUM_REGS);

    typedef struct packed {
        phase_e           phase;
        byte_e            kind;
        logic [2:0]       bitcnt;
        logic [7:0]       shreg;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] widx;
        logic             oe;
        logic             wr;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else if (start_det) begin
            st_d.phase  = PH_SHIFT;
            st_d.kind   = BY_ADDR;
            st_d.bitcnt = '0;
            st_d.idx    = '0;
            st_d.oe     = 1'b0;
        end else if (stop_det) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else begin
            case (st_q.phase)
                PH_SHIFT: begin
                    if (scl_rise) begin
                        st_d.shreg  = {st_q.shreg[6:0], sda_s};
                        st_d.bitcnt = st_q.bitcnt + 3'd1;
                        if (st_q.bitcnt == 3'd7) begin
                            st_d.phase = PH_WAITFALL;
                        end
                    end
                end
                PH_WAITFALL: begin
                    if (scl_fall) begin
                        if (st_q.kind == BY_ADDR && st_q.shreg != MATCH_BYTE) begin
                            st_d.phase = PH_IDLE;
                        end else begin
                            st_d.phase = PH_ACK;
                            st_d.oe    = 1'b1;
                            if (st_q.kind == BY_DATA && st_q.idx < IDX_LIMIT) begin
                                st_d.wr   = 1'b1;
                                st_d.widx = st_q.idx;
                                st_d.idx  = st_q.idx + 1'b1;
                            end
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.oe     = 1'b0;
                        st_d.phase  = PH_SHIFT;
                        st_d.bitcnt = '0;
                        st_d.kind   = next_kind(st_q.kind);
                    end
                end
                default: begin
                    st_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, kind: BY_ADDR, bitcnt: '0, shreg: '0,
                      idx: '0, widx: '0, oe: 1'b0, wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe  = st_q.oe;
    assign wr_en   = st_q.wr;
    assign wr_idx  = st_q.widx;
    assign wr_data = st_q.shreg;

endmodule

// File: rtl/i2cwo_regbank.sv
module i2cwo_regbank #(
    parameter int  NUM_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] ctrl_o
);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (enable && wr_en && wr_idx == IDX_W'(g)) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= 8'hFF;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign ctrl_o[g*8 +: 8] = regs_q[g];
    end

endmodule

// File: rtl/cfg_i2c_wo_slave.sv
module cfg_i2c_wo_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_dn_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] ctrl_o
);

    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    i2cwo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cwo_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (pwr_dn_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    i2cwo_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (pwr_dn_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ctrl_o  (ctrl_o)
    );

endmodule

// File: rtl/i2cwo_chk.sv
module i2cwo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pwr_dn_n,
    input logic         scl_i,
    input logic         sda_oe,
    input logic [W-1:0] ctrl_o
);

    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> !sda_oe);

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> $stable(ctrl_o));

    // R10
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R10
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_i);

    // R11
    wr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> $past(sda_oe));

endmodule

bind cfg_i2c_wo_slave i2cwo_chk #(.W(NUM_REGS * 8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .ctrl_o   (ctrl_o)
);

// File: tb/cfg_i2c_wo_slave_tb.sv
module cfg_i2c_wo_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int NREG       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_dn_n = 1'b1;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic [NREG*8-1:0] ctrl_o;
    logic            sda_line;

    assign sda_line = sda_m & ~sda_oe;

    cfg_i2c_wo_slave #(.NUM_REGS(NREG)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn_n (pwr_dn_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .ctrl_o   (ctrl_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic  exp_q[$];
    string tag_q[$];
    logic  ack_seen;
    event  ack_ev;

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic bus_start();
        wq(Q); sda_m = 1'b1;
        wq(Q); scl_m = 1'b1;
        wq(2 * Q); sda_m = 1'b0;
        wq(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_m = 1'b0;
        wq(Q); scl_m = 1'b1;
        wq(2 * Q); sda_m = 1'b1;
        wq(2 * Q);
    endtask

    // exp_ack: 0 = acknowledged (line low), 1 = not acknowledged
    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = b[i];
            wq(Q); scl_m = 1'b1;
            wq(2 * Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = 1'b1;
        wq(Q); scl_m = 1'b1;
        wq(Q); ack_seen = sda_line; ->ack_ev;
        wq(Q); scl_m = 1'b0;
        wq(Q);
        // R10: line released again while SCL is low, before the next bit
        check(sda_oe == 1'b0, "R10 released after ack", 32'(sda_oe), 32'h0);
    endtask

    // scoreboard monitor: compare each observed acknowledge with the prediction
    initial begin
        forever begin
            @(ack_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard unexpected ack", 32'(ack_seen), 32'h1);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ack_seen == e, t, 32'(ack_seen), 32'(e));
            end
        end
    end

    initial begin
        wq(150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog act=running exp=done");
            finish_run();
        end
    end

    initial begin
        wq(3);
        // R1: reset state
        check(ctrl_o == 32'hFFFF_FFFF, "R1 reset registers", ctrl_o, 32'hFFFF_FFFF);
        check(sda_oe == 1'b0, "R1 reset sda released", 32'(sda_oe), 32'h0);
        rst_n = 1'b1;
        wq(5);

        // R3 R5 R6: normal write of two registers
        bus_start();
        send(8'hD2, 1'b0, "R3 address ack");
        send(8'h5A, 1'b0, "R5 command ack");
        send(8'h01, 1'b0, "R5 count ack");
        send(8'hA5, 1'b0, "R6 data0 ack");
        send(8'h3C, 1'b0, "R6 data1 ack");
        bus_stop();
        check(ctrl_o == 32'hFFFF_3CA5, "R6 in-order load", ctrl_o, 32'hFFFF_3CA5);

        // R4: wrong address, nothing acked, nothing written
        bus_start();
        send(8'hD4, 1'b1, "R4 foreign address nack");
        send(8'h00, 1'b1, "R4 following byte nack");
        bus_stop();
        check(ctrl_o == 32'hFFFF_3CA5, "R4 R11 no write after foreign address", ctrl_o, 32'hFFFF_3CA5);

        // R4: read form of own address
        bus_start();
        send(8'hD3, 1'b1, "R4 read address nack");
        send(8'h00, 1'b1, "R4 byte after read nack");
        bus_stop();
        check(ctrl_o == 32'hFFFF_3CA5, "R4 no write after read", ctrl_o, 32'hFFFF_3CA5);

        // R7: overflow beyond last register
        bus_start();
        send(8'hD2, 1'b0, "R3 address ack");
        send(8'hFF, 1'b0, "R5 command ack");
        send(8'h00, 1'b0, "R5 count ack");
        send(8'h11, 1'b0, "R6 data ack");
        send(8'h22, 1'b0, "R6 data ack");
        send(8'h33, 1'b0, "R6 data ack");
        send(8'h44, 1'b0, "R6 data ack");
        send(8'h55, 1'b0, "R7 extra ack");
        send(8'h66, 1'b0, "R7 extra ack");
        bus_stop();
        check(ctrl_o == 32'h4433_2211, "R7 extras discarded", ctrl_o, 32'h4433_2211);

        // R8: repeated start resets the index
        bus_start();
        send(8'hD2, 1'b0, "R8 address ack");
        send(8'h12, 1'b0, "R8 command ack");
        send(8'h34, 1'b0, "R8 count ack");
        send(8'h0F, 1'b0, "R8 first data ack");
        bus_start();
        send(8'hD2, 1'b0, "R8 address after restart ack");
        send(8'h00, 1'b0, "R8 command ack");
        send(8'h00, 1'b0, "R8 count ack");
        send(8'hF0, 1'b0, "R8 data ack");
        send(8'h81, 1'b0, "R8 data ack");
        bus_stop();
        check(ctrl_o == 32'h4433_81F0, "R8 restart from reg0", ctrl_o, 32'h4433_81F0);

        // R2: stop ends a transfer early; the next one starts at the address
        bus_start();
        send(8'hD2, 1'b0, "R2 address ack");
        send(8'h77, 1'b0, "R2 command ack");
        bus_stop();
        bus_start();
        send(8'hD2, 1'b0, "R2 address ack");
        send(8'h9A, 1'b0, "R5 command ack");
        send(8'hBC, 1'b0, "R5 count ack");
        send(8'h77, 1'b0, "R2 data ack");
        bus_stop();
        check(ctrl_o == 32'h4433_8177, "R2 new transfer after stop", ctrl_o, 32'h4433_8177);

        // R9: power-down ignores the bus and retains registers
        pwr_dn_n = 1'b0;
        wq(4);
        bus_start();
        send(8'hD2, 1'b1, "R9 address nack in power-down");
        send(8'h00, 1'b1, "R9 nack in power-down");
        send(8'h00, 1'b1, "R9 nack in power-down");
        send(8'h99, 1'b1, "R9 nack in power-down");
        bus_stop();
        check(ctrl_o == 32'h4433_8177, "R9 R11 registers retained", ctrl_o, 32'h4433_8177);
        pwr_dn_n = 1'b1;
        wq(4);
        bus_start();
        send(8'hD2, 1'b0, "R9 address ack after wake");
        send(8'h00, 1'b0, "R9 command ack");
        send(8'h00, 1'b0, "R9 count ack");
        send(8'h5C, 1'b0, "R9 data ack");
        bus_stop();
        check(ctrl_o == 32'h4433_815C, "R9 normal after wake", ctrl_o, 32'h4433_815C);

        wq(4);
        check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        finish_run();
    end

endmodule